// File: doc/BRIEF.md
# Speculative Branch Tag Tracker with Selective Flush

This block keeps track of the speculated branches that are in flight in an out-of-order core. When a branch is dispatched it receives a tag from a small pool. Every instruction dispatched afterwards records the set of tags that are live at that moment. That set names every unresolved branch the instruction was fetched behind.

Branches resolve out of order. A branch that resolves correctly releases its tag, and the tag is removed from every recorded set. A mispredicting branch kills its own tag and every tag handed out after it. It also produces a mask over the instruction window that marks every instruction recorded under the killed tag. At the same time it sends the corrected target to fetch and to the predictor. Recovery therefore starts at resolution and does not wait for older branches or for retirement.

The pool remembers the order in which tags were given out. This order decides which path is younger, and it also decides which mispredict wins when two resolve in the same cycle.

Top module: `bt_tag_tracker`

## Requirements
- R1: After reset, `flushValid`, `redirValid` and `updValid` are low and `flushMask` is zero. All tags are free, so a branch sees `dispReady` high and `dispTag` equal to 0.
- R2: A branch dispatch is offered the lowest-numbered free tag on `dispTag`, in the same cycle. The tag is live from the next cycle on.
- R3: While every tag is live, `dispReady` is low for a branch and nothing is recorded. A non-branch still sees `dispReady` high and is accepted.
- R4: An accepted dispatch into slot s records the tags that are live in that cycle, minus any tag resolving correctly in that same cycle. When tag T mispredicts, bit s of `flushMask` is set in the following cycle exactly for the slots whose recorded set contains T. Bit s corresponds to window slot index s. Flushed slots then hold an empty set.
- R5: In the cycle after a mispredict is accepted, `redirValid` and `updValid` are both high. `redirTarget` and `updTarget` both carry the target given on the winning resolve lane.
- R6: A correct resolve frees the tag and removes it from every recorded set. If that tag number is handed out again later, a mispredict of the new owner does not flush the instructions recorded under the old owner.
- R7: A mispredict frees its own tag and every tag allocated after it. Older tags stay live.
- R8: When several lanes mispredict in the same cycle, only the lane whose tag was allocated earliest is acted on. The others are ignored: their targets are not sent out.
- R9: A younger branch can mispredict while an older one is still unresolved. Only the instructions behind the younger tag are flushed, and the older tag stays live.
- R10: An instruction accepted in the same cycle as a mispredict is marked in that flush mask. If it is a branch, it takes no tag.
- R11: In a cycle after which no mispredict was accepted, `flushValid` is low and `flushMask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | An instruction is offered for dispatch |
| dispIsBranch | input | 1 | The offered instruction is a speculated branch needing a tag |
| dispSlot | input | SLOT_W | Window slot the instruction occupies |
| dispReady | output | 1 | The dispatch is accepted this cycle |
| dispTag | output | TAG_W | Tag given to the offered branch |
| resValid | input | RES_N | Per lane: a branch resolves |
| resMiss | input | RES_N | Per lane: the branch was mispredicted |
| resTag | input | RES_N x TAG_W | Per lane: tag of the resolving branch |
| resTarget | input | RES_N x ADDR_W | Per lane: corrected target address |
| flushValid | output | 1 | A flush mask is presented |
| flushMask | output | SLOT_N | One bit per window slot to be killed |
| redirValid | output | 1 | Fetch redirect valid |
| redirTarget | output | ADDR_W | Fetch redirect address |
| updValid | output | 1 | Predictor correction valid |
| updTarget | output | ADDR_W | Predictor correction address |

## Verification
The bench goes after the following corners.

- Two lanes mispredicting together with the younger tag on the lower lane. A design that picks by lane index would redirect to the wrong target and flush too little.
- A younger mispredict while an older branch is pending. A design that kills by tag number instead of by allocation order would flush the older path too.
- A tag that is freed by a correct resolve and then handed out again. A design that does not scrub the freed bit from recorded sets would flush stale instructions when the new owner mispredicts.
- A dispatch in the same cycle as a mispredict. A design that misses this would leave a wrong-path instruction alive or leak a tag.
- A full pool. A design that misses this would hand out a live tag twice.

// File: rtl/bt_pkg.sv
package bt_pkg;
  parameter int TAG_N  = 4;
  parameter int SLOT_N = 8;
  parameter int ADDR_W = 32;
  parameter int RES_N  = 2;

  localparam int TAG_W  = (TAG_N > 1) ? $clog2(TAG_N) : 1;
  localparam int SLOT_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;
  localparam int PORT_W = (RES_N > 1) ? $clog2(RES_N) : 1;

  // Strobes from control to datapath, valid within one cycle
  typedef struct packed {
    logic              killValid;   // a mispredict is accepted
    logic [PORT_W-1:0] killPort;    // lane that won
    logic [TAG_N-1:0]  killOwn;     // one-hot tag of the winning branch
    logic [TAG_N-1:0]  killBits;    // that tag plus all younger live tags
    logic [TAG_N-1:0]  clearBits;   // tags resolving correctly
    logic              dispAccept;  // dispatch accepted
    logic              allocValid;  // a tag is handed out
    logic [TAG_N-1:0]  allocBit;    // one-hot of that tag
  } strobe_t;

  function automatic logic [TAG_N-1:0] tagBit(input logic [TAG_W-1:0] idx);
    logic [TAG_N-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         dispValid,
  input  logic                         dispIsBranch,
  input  logic [RES_N-1:0]             resValid,
  input  logic [RES_N-1:0]             resMiss,
  input  logic [RES_N-1:0][TAG_W-1:0]  resTag,
  output logic                         dispReady,
  output logic [TAG_W-1:0]             dispTag,
  output logic [TAG_N-1:0]             liveTags,
  output strobe_t                      strobe
);
  logic [TAG_N-1:0] liveQ;
  logic [TAG_N-1:0] olderQ [TAG_N];   // olderQ[i][j]: tag i allocated before tag j
  logic [RES_N-1:0] missVec;
  logic [RES_N-1:0] winVec;
  logic [TAG_W-1:0] killIdx;
  logic [TAG_W-1:0] allocIdx;
  logic             anyFree;

  assign liveTags = liveQ;
  assign missVec  = resValid & resMiss;

  always_comb begin
    strobe  = '0;
    winVec  = '0;
    killIdx = '0;
    // a mispredicting lane wins when every other mispredicting lane is younger
    for (int p = 0; p < RES_N; p++) begin
      winVec[p] = missVec[p];
      for (int q = 0; q < RES_N; q++) begin
        if (q != p && missVec[q] && !olderQ[resTag[p]][resTag[q]]) winVec[p] = 1'b0;
      end
    end
    for (int p = RES_N - 1; p >= 0; p--) begin
      if (winVec[p]) begin
        strobe.killPort = PORT_W'(p);
        killIdx         = resTag[p];
      end
    end
    strobe.killValid = |winVec;
    if (strobe.killValid) begin
      strobe.killOwn  = tagBit(killIdx);
      strobe.killBits = tagBit(killIdx) | (olderQ[killIdx] & liveQ);
    end
    for (int p = 0; p < RES_N; p++) begin
      if (resValid[p] && !resMiss[p]) strobe.clearBits = strobe.clearBits | tagBit(resTag[p]);
    end
    anyFree  = ~&liveQ;
    allocIdx = '0;
    for (int t = TAG_N - 1; t >= 0; t--) begin
      if (!liveQ[t]) allocIdx = TAG_W'(t);
    end
    dispReady         = !dispIsBranch || anyFree;
    dispTag           = allocIdx;
    strobe.dispAccept = dispValid && dispReady;
    strobe.allocValid = strobe.dispAccept && dispIsBranch && !strobe.killValid;
    strobe.allocBit   = strobe.allocValid ? tagBit(allocIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ <= '0;
      for (int i = 0; i < TAG_N; i++) olderQ[i] <= '0;
    end else begin
      liveQ <= (liveQ & ~strobe.killBits & ~strobe.clearBits) | strobe.allocBit;
      if (strobe.allocValid) begin
        olderQ[allocIdx] <= '0;
        for (int j = 0; j < TAG_N; j++) begin
          olderQ[j][allocIdx] <= liveQ[j] & ~strobe.clearBits[j];
        end
      end
    end
  end

  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (&liveQ && dispIsBranch) |-> !dispReady);                                  // R3
  AST_ALLOC_GOES_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocValid |=> |(liveQ & $past(strobe.allocBit)));                   // R2
  AST_KILL_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killValid |=> (liveQ & $past(strobe.killBits)) == '0);               // R7
  AST_SINGLE_KILL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.killOwn));                                                  // R8
endmodule

// File: rtl/bt_dpath.sv
module bt_dpath
  import bt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  input  logic [SLOT_W-1:0]             dispSlot,
  input  logic [TAG_N-1:0]              liveTags,
  input  logic [RES_N-1:0][ADDR_W-1:0]  resTarget,
  output logic                          flushValid,
  output logic [SLOT_N-1:0]             flushMask,
  output logic                          redirValid,
  output logic [ADDR_W-1:0]             redirTarget,
  output logic                          updValid,
  output logic [ADDR_W-1:0]             updTarget
);
  logic [SLOT_N-1:0] flushNext;

  for (genvar s = 0; s < SLOT_N; s++) begin : gSlot
    logic [TAG_N-1:0] maskQ;
    logic             dispHere;
    logic             hit;
    assign dispHere     = strobe.dispAccept && (dispSlot == SLOT_W'(s));
    assign hit          = |(maskQ & strobe.killOwn);
    assign flushNext[s] = strobe.killValid && (hit || dispHere);

    always_ff @(posedge clk) begin
      if (!rstN)         maskQ <= '0;
      else if (dispHere) maskQ <= strobe.killValid ? '0 : (liveTags & ~strobe.clearBits);
      else if (hit)      maskQ <= '0;
      else               maskQ <= maskQ & ~strobe.clearBits;
    end

    AST_FLUSHED_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
      flushMask[s] |-> maskQ == '0);                                            // R4
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushValid  <= 1'b0;
      flushMask   <= '0;
      redirValid  <= 1'b0;
      updValid    <= 1'b0;
      redirTarget <= '0;
      updTarget   <= '0;
    end else begin
      flushValid <= strobe.killValid;
      flushMask  <= flushNext;
      redirValid <= strobe.killValid;
      updValid   <= strobe.killValid;
      if (strobe.killValid) begin
        redirTarget <= resTarget[strobe.killPort];
        updTarget   <= resTarget[strobe.killPort];
      end
    end
  end

  AST_QUIET_NO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !flushValid |-> flushMask == '0);                                           // R11
  AST_REDIRECT_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (redirValid && updValid && redirTarget == updTarget));       // R5
endmodule

// File: rtl/bt_tag_tracker.sv
module bt_tag_tracker
  import bt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          dispValid,
  input  logic                          dispIsBranch,
  input  logic [SLOT_W-1:0]             dispSlot,
  output logic                          dispReady,
  output logic [TAG_W-1:0]              dispTag,
  input  logic [RES_N-1:0]              resValid,
  input  logic [RES_N-1:0]              resMiss,
  input  logic [RES_N-1:0][TAG_W-1:0]   resTag,
  input  logic [RES_N-1:0][ADDR_W-1:0]  resTarget,
  output logic                          flushValid,
  output logic [SLOT_N-1:0]             flushMask,
  output logic                          redirValid,
  output logic [ADDR_W-1:0]             redirTarget,
  output logic                          updValid,
  output logic [ADDR_W-1:0]             updTarget
);
  strobe_t          strobe;
  logic [TAG_N-1:0] liveTags;

  bt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispIsBranch(dispIsBranch),
    .resValid(resValid), .resMiss(resMiss), .resTag(resTag),
    .dispReady(dispReady), .dispTag(dispTag), .liveTags(liveTags), .strobe(strobe)
  );

  bt_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dispSlot(dispSlot), .liveTags(liveTags),
    .resTarget(resTarget), .flushValid(flushValid), .flushMask(flushMask),
    .redirValid(redirValid), .redirTarget(redirTarget),
    .updValid(updValid), .updTarget(updTarget)
  );
endmodule

// File: tb/tb_bt_tag_tracker.sv
module tb_bt_tag_tracker;
  import bt_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0, dispIsBranch = 1'b0;
  logic [SLOT_W-1:0] dispSlot = '0;
  logic dispReady;
  logic [TAG_W-1:0] dispTag;
  logic [RES_N-1:0] resValid = '0, resMiss = '0;
  logic [RES_N-1:0][TAG_W-1:0] resTag = '0;
  logic [RES_N-1:0][ADDR_W-1:0] resTarget = '0;
  logic flushValid, redirValid, updValid;
  logic [SLOT_N-1:0] flushMask;
  logic [ADDR_W-1:0] redirTarget, updTarget;

  bt_tag_tracker dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  string focus = "R4";
  logic [TAG_N-1:0] mLive;
  logic [TAG_N-1:0] mSlot [SLOT_N];
  int mSeq [TAG_N];
  int seqCount = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // one cycle: inputs already set; inputs change 1ns after a rising edge
  task automatic step();
    bit anyFree, expReady, accept;
    int win, lowFree;
    logic [SLOT_N-1:0] expMask;
    logic [TAG_N-1:0] clr, killSet;
    #2;
    anyFree = ~&mLive;
    lowFree = 0;
    for (int t = TAG_N - 1; t >= 0; t--) if (!mLive[t]) lowFree = t;
    expReady = !dispIsBranch || anyFree;
    if (dispValid || dispIsBranch) chk(dispReady == expReady, "R3 dispReady", 64'(dispReady), 64'(expReady));
    if (dispIsBranch && anyFree) chk(dispTag == TAG_W'(lowFree), "R2 dispTag", 64'(dispTag), 64'(lowFree));
    win = -1;
    for (int p = 0; p < RES_N; p++)
      if (resValid[p] && resMiss[p] && (win < 0 || mSeq[resTag[p]] < mSeq[resTag[win]])) win = p;
    accept = dispValid && expReady;
    expMask = '0;
    for (int s = 0; s < SLOT_N; s++)
      if (win >= 0 && (mSlot[s][resTag[win]] || (accept && dispSlot == SLOT_W'(s)))) expMask[s] = 1'b1;
    @(posedge clk); #1;
    chk(flushValid == (win >= 0), (win >= 0) ? focus : "R11 flushValid", 64'(flushValid), 64'(win >= 0));
    chk(flushMask == expMask, (win >= 0) ? focus : "R11 flushMask", 64'(flushMask), 64'(expMask));
    if (win >= 0) begin
      chk(redirValid && updValid, "R5 valid", 64'({redirValid, updValid}), 64'd3);
      chk(redirTarget == resTarget[win], "R5 redirTarget", 64'(redirTarget), 64'(resTarget[win]));
      chk(updTarget == resTarget[win], "R5 updTarget", 64'(updTarget), 64'(resTarget[win]));
    end
    // reference update
    clr = '0;
    for (int p = 0; p < RES_N; p++) if (resValid[p] && !resMiss[p]) clr[resTag[p]] = 1'b1;
    killSet = '0;
    if (win >= 0)
      for (int t = 0; t < TAG_N; t++) if (mLive[t] && mSeq[t] >= mSeq[resTag[win]]) killSet[t] = 1'b1;
    for (int s = 0; s < SLOT_N; s++) begin
      if (accept && dispSlot == SLOT_W'(s)) mSlot[s] = (win >= 0) ? '0 : (mLive & ~clr);
      else if (win >= 0 && mSlot[s][resTag[win]]) mSlot[s] = '0;
      else mSlot[s] = mSlot[s] & ~clr;
    end
    mLive = mLive & ~killSet & ~clr;
    if (accept && dispIsBranch && win < 0) begin
      mLive[lowFree] = 1'b1;
      mSeq[lowFree] = seqCount++;
    end
    dispValid = 0; dispIsBranch = 0; resValid = '0; resMiss = '0;
  endtask

  task automatic disp(input bit br, input int slot);
    dispValid = 1; dispIsBranch = br; dispSlot = SLOT_W'(slot);
  endtask

  task automatic res(input int p, input int tag, input bit miss, input logic [ADDR_W-1:0] tgt);
    resValid[p] = 1; resMiss[p] = miss; resTag[p] = TAG_W'(tag); resTarget[p] = tgt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    mLive = '0;
    for (int s = 0; s < SLOT_N; s++) mSlot[s] = '0;
    for (int t = 0; t < TAG_N; t++) mSeq[t] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    // R1: quiet outputs and an empty pool after reset
    chk(!flushValid && !redirValid && !updValid && flushMask == '0, "R1 outputs",
        64'({flushValid, redirValid, updValid}), 64'd0);
    dispIsBranch = 1; #1;
    chk(dispReady && dispTag == '0, "R1 pool", 64'({dispReady, dispTag}), 64'({1'b1, TAG_W'(0)}));
    dispIsBranch = 0;

    // fill the pool: tags 0..3 on slots 0,2,4,5
    disp(1, 0); step();
    disp(0, 1); step();
    disp(1, 2); step();
    disp(0, 3); step();
    disp(1, 4); step();
    disp(1, 5); step();
    focus = "R3"; disp(1, 6); step();   // R3 stall
    disp(0, 6); step();                 // R3 non-branch still accepted
    // R8: tag 2 (younger) on lane 0, tag 1 (older) on lane 1
    focus = "R8";
    res(0, 2, 1, 32'hAAAA_0000); res(1, 1, 1, 32'h1111_0000); step();
    // R9: younger path dies while tag 0 pending
    focus = "R9";
    disp(1, 3); step();
    disp(0, 4); step();
    res(0, 1, 1, 32'h2222_0000); step();
    // R10: dispatch during mispredict of tag 0
    focus = "R10";
    disp(1, 5); res(1, 0, 1, 32'h3333_0000); step();
    disp(1, 5); step();
    disp(1, 6); step();
    // R6: tag reuse after correct resolve
    focus = "R6";
    res(0, 0, 0, 32'h0); res(1, 1, 0, 32'h0); step();
    disp(0, 7); step();
    disp(1, 0); step();
    disp(0, 1); step();
    res(0, 0, 1, 32'h4444_0000); step();
    // R7: kill frees younger tags
    focus = "R7";
    disp(1, 2); step();
    disp(1, 3); step();
    disp(1, 4); step();
    res(1, 0, 1, 32'h5555_0000); step();

    // random mix
    focus = "R4";
    for (int c = 0; c < 3000; c++) begin
      int start, used;
      if ($urandom % 4 != 0) begin
        start = $urandom % SLOT_N;
        for (int k = 0; k < SLOT_N; k++) begin
          int s;
          s = (start + k) % SLOT_N;
          if (!dispValid && mSlot[s] == '0) disp(($urandom % 3) == 0, s);
        end
      end
      used = -1;
      for (int p = 0; p < RES_N; p++) begin
        if ($urandom % 2 == 0) begin
          int t;
          t = $urandom % TAG_N;
          if (mLive[t] && t != used) begin
            res(p, t, ($urandom % 4) == 0, $urandom);
            used = t;
          end
        end
      end
      step();
    end
    finishRun();
  end
endmodule